// File: doc/BRIEF.md
# PCI Interrupt Pin Swizzle and Line Router

This block takes the four shared PCI interrupt lines of a host bridge and delivers them to a bank of interrupt-controller inputs. It has two independent halves. The swizzle half is purely combinational. It takes a device/function number and the interrupt pin the device uses. For devices in the four slots that start at a base slot, it returns a rotated line; for any other device it returns the pin unchanged.

The router half keeps the present level of each of the four lines. A line's level is updated by a one-cycle level event. Each line also has an 8-bit routing entry that names the controller input it feeds. Every controller output is registered and equals the OR of all enabled lines whose entry names it, so lines that share a target behave as a wired-OR. The routing entries are written through a small register port and can be read back on the same port.

Top module: `irq_swizzle_router`

## Requirements
- R1: The slot is the device/function number divided by 8. For slots 18, 19, 20 and 21, the swizzled line equals ((slot - 18) + pin) mod 4. The result appears combinationally on `sw_line`.
- R2: For any slot outside 18..21, `sw_line` equals `sw_pin`.
- R3: After reset, all four routing entries read 0x80, all stored line levels are low, and `ctl_irq` is all zero.
- R4: A level event stores `line_evt_level` as the level of line `line_evt_idx` at the clock edge where `line_evt_valid` is high. The other lines keep their stored levels, and the new level reaches `ctl_irq` at the following edge.
- R5: On every clock edge, bit t of `ctl_irq` is loaded with the OR of the stored levels of all lines whose routing entry has bit 7 clear and bits 6:0 equal to t.
- R6: A routing entry with bit 7 set disables its line, and that line contributes to no output.
- R7: An output that no enabled entry targets is held low. An enabled entry whose bits 6:0 are 16 or more drives no output.
- R8: A write with `cfg_wr_en` high stores all 8 bits of `cfg_wdata` into entry `cfg_addr` at that edge. `cfg_rdata` shows the entry selected by `cfg_addr` combinationally, and the new routing affects `ctl_irq` at the following edge.
- R9: When several enabled lines name the same target, that output is high if any one of them is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_devfn | input | 8 | Device/function number for the swizzle |
| sw_pin | input | 2 | Device interrupt pin (0=A .. 3=D) |
| sw_line | output | 2 | Swizzled PCI line |
| line_evt_valid | input | 1 | Level event strobe |
| line_evt_idx | input | 2 | Line whose level is reported |
| line_evt_level | input | 1 | New level of that line |
| cfg_wr_en | input | 1 | Routing entry write strobe |
| cfg_addr | input | 2 | Routing entry index for write and read |
| cfg_wdata | input | 8 | Routing entry write data |
| cfg_rdata | output | 8 | Routing entry selected by cfg_addr |
| ctl_irq | output | 16 | Controller input levels |

## Verification
A wrong stored line level shows up on the targeted `ctl_irq` bit one edge after the event. A wrong routing entry shows up in two places: at once on `cfg_rdata`, and one edge later as a missing or stray output bit. The swizzle has no state, so a wrong rotation is visible on `sw_line` in the same cycle. This is why every devfn and pin pair is swept. The routing sweeps cover all sixteen line-level patterns under configurations with shared, disabled and out-of-range targets.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned ROUTE_W = 8;
  typedef logic [ROUTE_W-1:0] route_t;
  // Top bit set marks the line as disconnected.
  localparam route_t ROUTE_OFF = route_t'(1) << (ROUTE_W - 1);

  // True when an entry is enabled and names the given controller input.
  function automatic logic route_targets(input route_t r, input int unsigned tgt);
    return !r[ROUTE_W-1] && (32'(r[ROUTE_W-2:0]) == tgt);
  endfunction
endpackage

// File: rtl/irq_swizzle.sv
module irq_swizzle #(
  parameter int unsigned DEVFN_W   = 8,
  parameter int unsigned FUNC_BITS = 3,
  parameter int unsigned LINES     = 4,
  parameter int unsigned BASE_SLOT = 18,
  localparam int unsigned SLOT_W = DEVFN_W - FUNC_BITS,
  localparam int unsigned LIDX_W = $clog2(LINES)
) (
  input  logic [DEVFN_W-1:0] devfn,
  input  logic [LIDX_W-1:0]  pin,
  output logic [SLOT_W-1:0]  slot,
  output logic               in_window,
  output logic [LIDX_W-1:0]  line
);
  function automatic logic [LIDX_W-1:0] rotate(input logic [SLOT_W-1:0] s,
                                               input logic [LIDX_W-1:0] p);
    logic [SLOT_W-1:0] ofs;
    logic [SLOT_W-1:0] sum;
    ofs = s - SLOT_W'(BASE_SLOT);
    sum = ofs + SLOT_W'(p);
    return sum[LIDX_W-1:0];
  endfunction

  always_comb begin
    slot      = SLOT_W'(devfn / (2 ** FUNC_BITS));
    in_window = (32'(slot) >= BASE_SLOT) && (32'(slot) < BASE_SLOT + LINES);
    line      = in_window ? rotate(slot, pin) : pin;
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned LINES = 4,
  localparam int unsigned LIDX_W = $clog2(LINES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [LIDX_W-1:0]             idx,
  input  route_t                        wr_data,
  output route_t                        rd_data,
  output logic [LINES-1:0][ROUTE_W-1:0] routes
);
  for (genvar i = 0; i < LINES; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        routes[i] <= ROUTE_OFF;
      else if (wr_en && (32'(idx) == i))
        routes[i] <= wr_data;
    end
  end

  assign rd_data = routes[idx];
endmodule

// File: rtl/irq_line_latch.sv
module irq_line_latch #(
  parameter int unsigned LINES = 4,
  localparam int unsigned LIDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [LIDX_W-1:0] evt_idx,
  input  logic              evt_level,
  output logic [LINES-1:0]  lvl
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)
        lvl[i] <= 1'b0;
      else if (evt_valid && (32'(evt_idx) == i))
        lvl[i] <= evt_level;
    end
  end
endmodule

// File: rtl/irq_route_merge.sv
module irq_route_merge
  import irq_route_pkg::*;
#(
  parameter int unsigned LINES   = 4,
  parameter int unsigned TARGETS = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LINES-1:0][ROUTE_W-1:0] routes,
  input  logic [LINES-1:0]              lvl,
  output logic [TARGETS-1:0]            tgt_mask,
  output logic [TARGETS-1:0]            irq_q
);
  logic [TARGETS-1:0] irq_d;

  for (genvar t = 0; t < TARGETS; t++) begin : g_tgt
    logic [LINES-1:0] hits;
    always_comb begin
      for (int i = 0; i < LINES; i++)
        hits[i] = route_targets(routes[i], t);
      tgt_mask[t] = |hits;
      irq_d[t]    = |(hits & lvl);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/irq_swizzle_router.sv
module irq_swizzle_router
  import irq_route_pkg::*;
#(
  parameter int unsigned DEVFN_W   = 8,
  parameter int unsigned FUNC_BITS = 3,
  parameter int unsigned LINES     = 4,
  parameter int unsigned BASE_SLOT = 18,
  parameter int unsigned TARGETS   = 16,
  localparam int unsigned LIDX_W = $clog2(LINES),
  localparam int unsigned SLOT_W = DEVFN_W - FUNC_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DEVFN_W-1:0] sw_devfn,
  input  logic [LIDX_W-1:0]  sw_pin,
  output logic [LIDX_W-1:0]  sw_line,
  input  logic               line_evt_valid,
  input  logic [LIDX_W-1:0]  line_evt_idx,
  input  logic               line_evt_level,
  input  logic               cfg_wr_en,
  input  logic [LIDX_W-1:0]  cfg_addr,
  input  logic [ROUTE_W-1:0] cfg_wdata,
  output logic [ROUTE_W-1:0] cfg_rdata,
  output logic [TARGETS-1:0] ctl_irq
);
  // Internal events named for the checker.
  logic [SLOT_W-1:0]              sw_slot;
  logic                           sw_in_window;
  logic [LINES-1:0]               line_lvl;
  logic [LINES-1:0][ROUTE_W-1:0]  route_tab;
  logic [TARGETS-1:0]             tgt_mask;

  irq_swizzle #(
    .DEVFN_W(DEVFN_W), .FUNC_BITS(FUNC_BITS), .LINES(LINES), .BASE_SLOT(BASE_SLOT)
  ) u_swz (
    .devfn(sw_devfn), .pin(sw_pin), .slot(sw_slot),
    .in_window(sw_in_window), .line(sw_line)
  );

  irq_route_regs #(.LINES(LINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .idx(cfg_addr),
    .wr_data(cfg_wdata), .rd_data(cfg_rdata), .routes(route_tab)
  );

  irq_line_latch #(.LINES(LINES)) u_lines (
    .clk(clk), .rst_n(rst_n), .evt_valid(line_evt_valid),
    .evt_idx(line_evt_idx), .evt_level(line_evt_level), .lvl(line_lvl)
  );

  irq_route_merge #(.LINES(LINES), .TARGETS(TARGETS)) u_merge (
    .clk(clk), .rst_n(rst_n), .routes(route_tab), .lvl(line_lvl),
    .tgt_mask(tgt_mask), .irq_q(ctl_irq)
  );
endmodule

// File: rtl/irq_route_checker.sv
module irq_route_checker
  import irq_route_pkg::*;
#(
  parameter int unsigned LINES     = 4,
  parameter int unsigned TARGETS   = 16,
  parameter int unsigned BASE_SLOT = 18,
  parameter int unsigned SLOT_W    = 5,
  localparam int unsigned LIDX_W = $clog2(LINES)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [SLOT_W-1:0]             sw_slot,
  input logic                          sw_in_window,
  input logic [LIDX_W-1:0]             sw_pin,
  input logic [LIDX_W-1:0]             sw_line,
  input logic                          line_evt_valid,
  input logic [LIDX_W-1:0]             line_evt_idx,
  input logic                          line_evt_level,
  input logic [LINES-1:0]              line_lvl,
  input logic                          cfg_wr_en,
  input logic [LIDX_W-1:0]             cfg_addr,
  input logic [ROUTE_W-1:0]            cfg_wdata,
  input logic [LINES-1:0][ROUTE_W-1:0] route_tab,
  input logic [TARGETS-1:0]            tgt_mask,
  input logic [TARGETS-1:0]            ctl_irq
);
  logic [LINES-1:0] off_bits;
  always_comb
    for (int i = 0; i < LINES; i++) off_bits[i] = route_tab[i][ROUTE_W-1];

  // R1: the base slot itself does not rotate
  a_r1_base_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(sw_slot) == BASE_SLOT) |-> (sw_line == sw_pin));
  // R1: the next slot rotates by one
  a_r1_next_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(sw_slot) == BASE_SLOT + 1) |-> (sw_line == LIDX_W'(sw_pin + 1'b1)));
  // R2: outside the window the pin passes through
  a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_in_window |-> (sw_line == sw_pin));
  // R4: an event loads the indexed line
  a_r4_line_load: assert property (@(posedge clk) disable iff (!rst_n)
    line_evt_valid |=> (line_lvl[$past(line_evt_idx)] == $past(line_evt_level)));
  // R4: without an event, levels hold
  a_r4_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_evt_valid |=> $stable(line_lvl));
  // R5: all lines low gives all outputs low
  a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (line_lvl == '0) |=> (ctl_irq == '0));
  // R6: all entries disabled gives no output
  a_r6_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (&off_bits) |=> (ctl_irq == '0));
  // R7: untargeted outputs stay low
  a_r7_untargeted_low: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 ((ctl_irq & ~$past(tgt_mask)) == '0));
  // R8: a write lands in the addressed entry
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> (route_tab[$past(cfg_addr)] == $past(cfg_wdata)));
endmodule

bind irq_swizzle_router irq_route_checker #(
  .LINES(LINES), .TARGETS(TARGETS), .BASE_SLOT(BASE_SLOT), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_slot(sw_slot), .sw_in_window(sw_in_window),
  .sw_pin(sw_pin), .sw_line(sw_line), .line_evt_valid(line_evt_valid),
  .line_evt_idx(line_evt_idx), .line_evt_level(line_evt_level),
  .line_lvl(line_lvl), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .route_tab(route_tab), .tgt_mask(tgt_mask),
  .ctl_irq(ctl_irq)
);

// File: tb/tb_irq_swizzle_router.sv
`timescale 1ns/1ps
module tb_irq_swizzle_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sw_devfn = '0;
  logic [1:0]  sw_pin = '0;
  logic [1:0]  sw_line;
  logic        line_evt_valid = 1'b0;
  logic [1:0]  line_evt_idx = '0;
  logic        line_evt_level = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [15:0] ctl_irq;

  int checks = 0;
  int fails  = 0;
  logic [7:0] m_route [4];
  logic       m_lvl [4];

  always #2.5 clk = ~clk;

  irq_swizzle_router dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_irq();
    logic [15:0] r = '0;
    for (int i = 0; i < 4; i++)
      if (m_route[i] < 8'd16 && m_lvl[i]) r[m_route[i][3:0]] = 1'b1;
    return r;
  endfunction

  task automatic put_route(input int idx, input logic [7:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = 2'(idx); cfg_wdata = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    m_route[idx] = v;
  endtask

  task automatic put_level(input int idx, input logic v);
    @(negedge clk);
    line_evt_valid = 1'b1; line_evt_idx = 2'(idx); line_evt_level = v;
    @(negedge clk);
    line_evt_valid = 1'b0;
    m_lvl[idx] = v;
  endtask

  function automatic logic [7:0] cfg_route(input int c, input int i);
    case (c)
      0: return 8'h05;
      1: return 8'(i);
      2: return (i == 1) ? 8'h8F : (i == 2) ? 8'h30 : 8'h0F;
      3: return 8'(12 + i);
      default: return 8'((c * 29 + i * 71 + 5) % 256) & 8'hAF;
    endcase
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_route[i] = 8'h80; m_lvl[i] = 1'b0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: reset state
    check("R3 ctl_irq", 32'(ctl_irq), 32'h0);
    for (int i = 0; i < 4; i++) begin
      cfg_addr = 2'(i); #1;
      check("R3 route entry", 32'(cfg_rdata), 32'h80);
    end

    // R1 / R2: exhaustive swizzle sweep
    for (int d = 0; d < 256; d++) begin
      for (int p = 0; p < 4; p++) begin
        int slot; int exp;
        sw_devfn = 8'(d); sw_pin = 2'(p); #1;
        slot = d / 8;
        if (slot >= 18 && slot <= 21) begin
          exp = ((slot - 18) + p) % 4;
          check("R1 swizzle window", 32'(sw_line), 32'(exp));
        end else
          check("R2 swizzle passthru", 32'(sw_line), 32'(p));
      end
    end

    // R6: disabled entries block every line
    for (int i = 0; i < 4; i++) put_level(i, 1'b1);
    @(negedge clk);
    check("R6 all disabled", 32'(ctl_irq), 32'h0);
    for (int i = 0; i < 4; i++) put_level(i, 1'b0);

    // R8: write timing and readback, one line high
    put_level(0, 1'b1);
    put_route(0, 8'h07);
    cfg_addr = 2'd0; #1;
    check("R8 readback", 32'(cfg_rdata), 32'h07);
    check("R8 not yet applied", 32'(ctl_irq), 32'h0);
    @(negedge clk);
    check("R8 applied next edge", 32'(ctl_irq), 32'h0080);

    // R4: identity routes, toggle one line, others keep their levels
    for (int i = 0; i < 4; i++) put_route(i, 8'(i));
    for (int i = 0; i < 4; i++) put_level(i, 1'b1);
    @(negedge clk);
    check("R4 all set", 32'(ctl_irq), 32'h000F);
    put_level(2, 1'b0);
    check("R4 before update", 32'(ctl_irq), 32'h000F);
    @(negedge clk);
    check("R4 one line cleared", 32'(ctl_irq), 32'h000B);

    // R5 / R7 / R9: configuration and level-pattern sweep
    for (int c = 0; c < 12; c++) begin
      for (int i = 0; i < 4; i++) put_route(i, cfg_route(c, i));
      for (int i = 0; i < 4; i++) begin
        cfg_addr = 2'(i); #1;
        check("R8 sweep readback", 32'(cfg_rdata), 32'(m_route[i]));
      end
      for (int lv = 0; lv < 16; lv++) begin
        for (int i = 0; i < 4; i++) put_level(i, lv[i]);
        @(negedge clk);
        check(c == 0 ? "R9 shared target" : "R5 R7 routed OR",
              32'(ctl_irq), 32'(model_irq()));
      end
    end

    summary();
    $finish;
  end
endmodule